// File: doc/BRIEF.md
# Weighted Pseudo-Random Test Bit Source

This block supplies biased pseudo-random stimulus bits for built-in self-test. A 16-stage maximal-length shift register with linear feedback produces bits that are one half the time. A per-output weighting stage then ANDs one, two, three or four of those bits, taken from fixed stages, and may invert the result. An input that needs a long run of ones or of zeros to expose a fault is therefore exercised far more often than it would be with unweighted bits.

Each output lane has a 3-bit weight code. A full set of codes for all lanes is one weight set. Three weight sets are stored, and a 2-bit index picks the active one, so a test program can switch between two or three weightings without rewriting them. A seed-load input restarts the sequence from a known state, and an enable input gates every step.

Top module: `weighted_pattern_gen`

## Requirements
- R1: After reset the register state is 16'hACE1, all three weight sets are zero and `patternOut` is all zeros.
- R2: On a clock edge where `enable` is 1 and `seedLoad` is 0, the state steps to {s[14:0], s[15]^s[13]^s[12]^s[10]} and `patternOut` takes the weighted bits computed from the state before the step. On any other edge both the state and `patternOut` hold.
- R3: Output lane i draws its ANDed bits from state stages (i) mod 16, (i+4) mod 16, (i+8) mod 16 and (i+12) mod 16, in that order of use.
- R4: The code of lane i is `cfgData[3i+2:3i]`: bit 0 is w1, bit 1 is w2, bit 2 inverts. {w1,w2} = 00 passes the first stage, 01 ANDs the first two, 10 the first three, 11 all four, giving ones-probabilities 1/2, 1/4, 1/8 and 1/16, or 1/2, 3/4, 7/8 and 15/16 when inverted.
- R5: When `seedLoad` is 1 the state takes `seedValue`, whatever `enable` is, and `patternOut` holds on that edge.
- R6: A seed load of all zeros places 16'hACE1 in the state instead, so the state is never all zeros.
- R7: A clock edge with `cfgWrEn` 1 and `cfgAddr` 0, 1 or 2 writes `cfgData` into that weight set; address 3 writes nothing and leaves all sets unchanged.
- R8: `setSel` 0, 1 or 2 makes that weight set active; `setSel` 3 applies code 000 to every lane.
- R9: Over 4096 enabled steps the fraction of ones on each lane lies within 0.035 of the probability that its code selects.
- R10: The register state is never all zeros while out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Steps the register and updates the outputs |
| seedLoad | input | 1 | Loads the seed, takes priority over enable |
| seedValue | input | 16 | Seed value; zero is replaced by the default seed |
| cfgWrEn | input | 1 | Weight-set write strobe |
| cfgAddr | input | 2 | Weight set written (0 to 2) |
| cfgData | input | 24 | Eight 3-bit lane codes, lane i at bits 3i+2:3i |
| setSel | input | 2 | Active weight set; 3 selects all-unweighted |
| patternOut | output | 8 | Registered weighted test bits |

## Verification
On every cycle the assertions hold that the state never becomes zero, that a step shifts the state by one stage, that the state and outputs freeze when no step is requested, that a nonzero seed lands exactly and blocks the output update, that a weight set changes only under its own write, and that an out-of-range index produces unweighted codes. Whether each lane draws from the right stages with the right AND width and inversion, and whether the measured ones-density matches each programmed weight, is visible only in the bench's scenarios, which compare every output against a cycle-exact model and tally densities over long runs for all eight codes in three weight sets.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
  localparam int unsigned CODE_W = 3;

  typedef struct packed {
    logic stepEn;
    logic seedEn;
  } bpgStrobe_t;

  typedef struct packed {
    logic invert;
    logic w2;
    logic w1;
  } weightCode_t;
endpackage

// File: rtl/bpg_ctrl.sv
module bpg_ctrl
  import bpg_pkg::*;
#(
  parameter int unsigned OUT_W    = 8,
  parameter int unsigned NUM_SETS = 3,
  parameter int unsigned SEL_W    = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      enable,
  input  logic                      seedLoad,
  input  logic                      cfgWrEn,
  input  logic [SEL_W-1:0]          cfgAddr,
  input  logic [OUT_W*CODE_W-1:0]   cfgData,
  input  logic [SEL_W-1:0]          setSel,
  output bpgStrobe_t                strobe,
  output logic [OUT_W*CODE_W-1:0]   activeWeights
);
  localparam int unsigned SET_BITS = OUT_W * CODE_W;

  logic [SET_BITS-1:0] setReg [NUM_SETS];

  // Seed load wins over a step request.
  always_comb begin
    strobe.seedEn = seedLoad;
    strobe.stepEn = enable & ~seedLoad;
  end

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rstN) setReg[s] <= '0;
      else if (cfgWrEn && (cfgAddr == SEL_W'(s))) setReg[s] <= cfgData;
    end

    assert_set_write_R7: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWrEn && (cfgAddr == SEL_W'(s))) |=> (setReg[s] == $past(cfgData)));

    assert_set_keep_R7: assert property (@(posedge clk) disable iff (!rstN)
      !(cfgWrEn && (cfgAddr == SEL_W'(s))) |=> $stable(setReg[s]));
  end

  always_comb begin
    activeWeights = '0;
    for (int s = 0; s < NUM_SETS; s++) begin
      if (setSel == SEL_W'(s)) activeWeights = setReg[s];
    end
  end

  assert_unweighted_sel_R8: assert property (@(posedge clk) disable iff (!rstN)
    (setSel >= SEL_W'(NUM_SETS)) |-> (activeWeights == '0));
endmodule

// File: rtl/bpg_datapath.sv
module bpg_datapath
  import bpg_pkg::*;
#(
  parameter int unsigned          LFSR_W       = 16,
  parameter int unsigned          OUT_W        = 8,
  parameter logic [LFSR_W-1:0]    TAP_MASK     = 16'hB400,
  parameter logic [LFSR_W-1:0]    DEFAULT_SEED = 16'hACE1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  bpgStrobe_t                strobe,
  input  logic [LFSR_W-1:0]         seedValue,
  input  logic [OUT_W*CODE_W-1:0]   activeWeights,
  output logic [OUT_W-1:0]          patternOut
);
  localparam int unsigned STRIDE = LFSR_W / 4;

  logic [LFSR_W-1:0] lfsr;
  logic [LFSR_W-1:0] lfsrNext;
  logic [LFSR_W-1:0] seedSafe;
  logic [OUT_W-1:0]  weightedBits;

  always_comb begin
    lfsrNext = {lfsr[LFSR_W-2:0], ^(lfsr & TAP_MASK)};
    seedSafe = (seedValue == '0) ? DEFAULT_SEED : seedValue;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              lfsr <= DEFAULT_SEED;
    else if (strobe.seedEn) lfsr <= seedSafe;
    else if (strobe.stepEn) lfsr <= lfsrNext;
  end

  for (genvar i = 0; i < OUT_W; i++) begin : g_lane
    localparam int unsigned P0 = i % LFSR_W;
    localparam int unsigned P1 = (i + STRIDE) % LFSR_W;
    localparam int unsigned P2 = (i + 2 * STRIDE) % LFSR_W;
    localparam int unsigned P3 = (i + 3 * STRIDE) % LFSR_W;

    weightCode_t code;
    logic        andBit;

    always_comb begin
      code = weightCode_t'(activeWeights[CODE_W*i +: CODE_W]);
      unique case ({code.w1, code.w2})
        2'b00:   andBit = lfsr[P0];
        2'b01:   andBit = lfsr[P0] & lfsr[P1];
        2'b10:   andBit = lfsr[P0] & lfsr[P1] & lfsr[P2];
        default: andBit = lfsr[P0] & lfsr[P1] & lfsr[P2] & lfsr[P3];
      endcase
      weightedBits[i] = andBit ^ code.invert;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              patternOut <= '0;
    else if (strobe.stepEn) patternOut <= weightedBits;
  end

  assert_state_nonzero_R10: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != '0);

  assert_step_shifts_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepEn |=> (lfsr[LFSR_W-1:1] == $past(lfsr[LFSR_W-2:0])));

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.stepEn && !strobe.seedEn) |=> ($stable(lfsr) && $stable(patternOut)));

  assert_seed_lands_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.seedEn && (seedValue != '0)) |=> (lfsr == $past(seedValue)));

  assert_seed_blocks_out_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.seedEn |=> $stable(patternOut));
endmodule

// File: rtl/weighted_pattern_gen.sv
module weighted_pattern_gen
  import bpg_pkg::*;
#(
  parameter int unsigned LFSR_W   = 16,
  parameter int unsigned OUT_W    = 8,
  parameter int unsigned NUM_SETS = 3,
  parameter int unsigned SEL_W    = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      enable,
  input  logic                      seedLoad,
  input  logic [LFSR_W-1:0]         seedValue,
  input  logic                      cfgWrEn,
  input  logic [SEL_W-1:0]          cfgAddr,
  input  logic [OUT_W*CODE_W-1:0]   cfgData,
  input  logic [SEL_W-1:0]          setSel,
  output logic [OUT_W-1:0]          patternOut
);
  bpgStrobe_t                strobe;
  logic [OUT_W*CODE_W-1:0]   activeWeights;

  bpg_ctrl #(
    .OUT_W(OUT_W), .NUM_SETS(NUM_SETS), .SEL_W(SEL_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .seedLoad(seedLoad),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .setSel(setSel), .strobe(strobe), .activeWeights(activeWeights)
  );

  bpg_datapath #(
    .LFSR_W(LFSR_W), .OUT_W(OUT_W)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .seedValue(seedValue),
    .activeWeights(activeWeights), .patternOut(patternOut)
  );
endmodule

// File: tb/weighted_pattern_gen_tb_top.sv
module weighted_pattern_gen_tb_top;
  localparam int NOUT = 8;
  localparam int CW   = 24;
  localparam int RUN  = 4096;
  localparam int TOL  = 144;
  localparam logic [15:0] DSEED = 16'hACE1;

  // Three weight sets, each holding all eight codes in a different lane order.
  localparam logic [CW-1:0] CFG_TABLE [3] = '{
    {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0},
    {3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7},
    {3'd3, 3'd2, 3'd1, 3'd0, 3'd7, 3'd6, 3'd5, 3'd4}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic seedLoad = 1'b0;
  logic [15:0] seedValue = '0;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgAddr = '0;
  logic [CW-1:0] cfgData = '0;
  logic [1:0] setSel = '0;
  logic [NOUT-1:0] patternOut;

  always #5 clk = ~clk;

  weighted_pattern_gen dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .seedLoad(seedLoad),
    .seedValue(seedValue), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .setSel(setSel), .patternOut(patternOut)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [15:0] mState = DSEED;
  logic [NOUT-1:0] mOut = '0;
  logic [CW-1:0] mSets [3] = '{default: '0};
  int onesCnt [NOUT];
  int mism;
  logic [NOUT-1:0] firstAct, firstExp;

  function automatic logic [15:0] stepOf(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [NOUT-1:0] laneBits(logic [15:0] s, logic [CW-1:0] cfg);
    logic [NOUT-1:0] r;
    for (int i = 0; i < NOUT; i++) begin
      logic a, b, c, d, v;
      logic [2:0] code;
      code = cfg[3*i +: 3];
      a = s[i % 16]; b = s[(i + 4) % 16]; c = s[(i + 8) % 16]; d = s[(i + 12) % 16];
      case (code[1:0])
        2'b00:   v = a;
        2'b10:   v = a & b;
        2'b01:   v = a & b & c;
        default: v = a & b & c & d;
      endcase
      r[i] = v ^ code[2];
    end
    return r;
  endfunction

  function automatic logic [CW-1:0] activeCfg();
    return (setSel == 2'd3) ? '0 : mSets[setSel];
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called just after a negedge; returns just after the next negedge.
  task automatic cycle(input logic en, input logic ld, input logic [15:0] sv);
    enable = en; seedLoad = ld; seedValue = sv;
    @(posedge clk);
    if (ld) mState = (sv == '0) ? DSEED : sv;
    else if (en) begin
      mOut = laneBits(mState, activeCfg());
      mState = stepOf(mState);
    end
    @(negedge clk);
  endtask

  task automatic runCompare(input int n);
    mism = 0;
    for (int i = 0; i < NOUT; i++) onesCnt[i] = 0;
    for (int k = 0; k < n; k++) begin
      cycle(1'b1, 1'b0, '0);
      if (patternOut !== mOut) begin
        if (mism == 0) begin firstAct = patternOut; firstExp = mOut; end
        mism++;
      end
      for (int i = 0; i < NOUT; i++) onesCnt[i] += int'(patternOut[i]);
    end
    enable = 1'b0;
  endtask

  task automatic writeSet(input logic [1:0] addr, input logic [CW-1:0] data);
    cfgWrEn = 1'b1; cfgAddr = addr; cfgData = data;
    @(posedge clk);
    if (addr != 2'd3) mSets[addr] = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NOUT-1:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(patternOut == '0, "R1 output after reset", patternOut, 0);
    runCompare(20);
    check(mism == 0, "R1/R2/R3 sequence from default seed, zero weights", firstAct, firstExp);

    // R7: program three sets
    for (int s = 0; s < 3; s++) writeSet(2'(s), CFG_TABLE[s]);

    // Table walk: R4 exact lanes, R9 densities
    for (int s = 0; s < 3; s++) begin
      setSel = 2'(s);
      runCompare(RUN);
      check(mism == 0, $sformatf("R4/R8 exact lanes set %0d", s), firstAct, firstExp);
      for (int i = 0; i < NOUT; i++) begin
        logic [2:0] code;
        int num, den, diff;
        code = CFG_TABLE[s][3*i +: 3];
        case (code[1:0])
          2'b00: den = 2;
          2'b10: den = 4;
          2'b01: den = 8;
          default: den = 16;
        endcase
        num = code[2] ? den - 1 : 1;
        diff = onesCnt[i] * den - num * RUN;
        if (diff < 0) diff = -diff;
        check(diff <= TOL * den, $sformatf("R9 density set %0d lane %0d", s, i),
              onesCnt[i], (num * RUN) / den);
      end
    end

    // R2: hold while not enabled, then resume from held state
    setSel = 2'd0;
    runCompare(3);
    held = patternOut;
    for (int k = 0; k < 5; k++) begin
      cycle(1'b0, 1'b0, '0);
      check(patternOut == held, "R2 output holds while disabled", patternOut, held);
    end
    runCompare(10);
    check(mism == 0, "R2 state held while disabled", firstAct, firstExp);

    // R5: seed load with enable high
    held = patternOut;
    cycle(1'b1, 1'b1, 16'h1234);
    check(patternOut == held, "R5 output holds on seed load", patternOut, held);
    runCompare(10);
    check(mism == 0, "R5 sequence from loaded seed", firstAct, firstExp);

    // R6: zero seed replaced
    cycle(1'b0, 1'b1, 16'h0000);
    runCompare(30);
    check(mism == 0, "R6 zero seed gives default seed", firstAct, firstExp);

    // R7: write to address 3 ignored
    writeSet(2'd3, '1);
    for (int s = 0; s < 3; s++) begin
      setSel = 2'(s);
      runCompare(100);
      check(mism == 0, $sformatf("R7 set %0d untouched by address 3", s), firstAct, firstExp);
    end

    // R8: index 3 unweighted
    setSel = 2'd3;
    runCompare(100);
    check(mism == 0, "R8 index 3 gives unweighted lanes", firstAct, firstExp);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule